// File: doc/BRIEF.md
# Segment Translation Unit with Descriptor Cache

This block holds six segment selector registers. Each one has a hidden descriptor cache beside it that software cannot write. When a selector is loaded, the block works out where its descriptor sits in memory. It takes the global table base or the local table base, picked by the table bit in the selector, and adds eight times the selector's index. It then fetches the 8-byte descriptor as two 32-bit reads through a simple read port and stores the descriptor base in that register's cache.

A translation request names a register and carries a 32-bit offset. It is served from the cached base alone and never touches memory. The result is the base plus the offset, and it arrives one cycle after the request is accepted. A selector whose table bit is clear and whose index is zero is a null selector. It can be loaded, but any later translation through that register reports a fault in place of an address. The privilege bits of the code register (register 0) are driven out as the current privilege level.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset the block behaves as follows. `busy_o` is 0, `mem_req_o` is 0, `ld_ready_o` is 1 and `cpl_o` is 0. Every cache entry is invalid, so a translation on any register faults.
- R2: The selector is split into index (bits 15:3), table bit (bit 2) and privilege (bits 1:0). The descriptor address is `gdt_base_i` when the table bit is 0, or `ldt_base_i` when it is 1, plus index×8, modulo 2^32. Both table bases are sampled in the cycle the load is accepted.
- R3: A fetch makes two reads. The first reads the descriptor address and returns the low word. The second reads that address +4 and returns the high word. Each read holds `mem_req_o` and a stable `mem_addr_o` until the cycle in which `mem_rvalid_i` is 1.
- R4: The cached base is {high[31:24], high[7:0], low[31:16]}.
- R5: `busy_o` rises in the cycle after a non-null load is accepted. It falls in the cycle after the second read returns. While `busy_o` is 1, `ld_ready_o` is 0, and a load offered in that time has no effect.
- R6: While a fetch is pending, a translation to the register being filled is stalled (`xl_ready_o` = 0) until the fill completes. Translations to other registers are accepted.
- R7: In the cycle after a translation is accepted, `xl_done_o` is 1, `xl_fault_o` is 0 and `xl_lin_o` is base + offset modulo 2^32, with no memory read.
- R8: A null selector (table bit 0, index 0) is loaded without a fetch, and `busy_o` stays 0. It leaves the entry invalid, so translation gives `xl_fault_o` = 1 and `xl_lin_o` = 0. A selector with table bit 1 and index 0 is not null and is fetched from the local table.
- R9: `cpl_o` equals bits 1:0 of the selector most recently loaded into register 0.
- R10: Only register numbers 0 to 5 exist. A load to 6 or 7 has no effect, and a translation on 6 or 7 faults.
- R11: A cached base does not change until its register is reloaded, even when the table bases change. A reload replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| gdt_base_i | input | 32 | Global descriptor table base |
| ldt_base_i | input | 32 | Local descriptor table base |
| ld_valid_i | input | 1 | Selector load request |
| ld_reg_i | input | 3 | Register number to load |
| ld_sel_i | input | 16 | Selector value |
| ld_ready_o | output | 1 | Load can be accepted |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Memory read byte address |
| mem_rvalid_i | input | 1 | Read data valid, completes the current read |
| mem_rdata_i | input | 32 | Read data |
| busy_o | output | 1 | Descriptor fetch in progress |
| xl_valid_i | input | 1 | Translation request |
| xl_reg_i | input | 3 | Register number to translate through |
| xl_off_i | input | 32 | Logical offset |
| xl_ready_o | output | 1 | Translation can be accepted |
| xl_done_o | output | 1 | Translation result valid |
| xl_lin_o | output | 32 | Linear address |
| xl_fault_o | output | 1 | Translation used an invalid entry |
| cpl_o | output | 2 | Current privilege level |

## Verification
A translation result appears one clock edge after acceptance. The bench therefore raises the request at a falling edge, waits for the next rising edge and samples 1 ns after it. `busy_o` is sampled 1 ns after the edge that accepts a load: it must already be 1 for a non-null selector and still 0 for a null one. The memory model answers each read after a random delay of 0 to 2 cycles, so the point at which a fill completes moves from load to load. For that reason the bench polls `busy_o` edge by edge instead of waiting a fixed count. It then compares the two addresses it logged for that fetch, and the base that a following translation returns, with values it computes itself from the selector and the table bases.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int SEL_W = 16;
  localparam int IDX_W = 13;
  localparam int AW    = 32;

  typedef struct packed {
    logic [IDX_W-1:0] index;
    logic             ti;
    logic [1:0]       rpl;
  } sel_t;

  function automatic logic sel_is_null(sel_t s);
    return (s.ti == 1'b0) && (s.index == '0);
  endfunction

  function automatic logic [AW-1:0] desc_base(logic [31:0] lo, logic [31:0] hi);
    return {hi[31:24], hi[7:0], lo[31:16]};
  endfunction
endpackage

// File: rtl/seg_desc_fetch.sv
module seg_desc_fetch
  import seg_xlate_pkg::*;
#(
  parameter int RW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [RW-1:0] start_reg_i,
  input  sel_t          sel_i,
  input  logic [AW-1:0] gdt_base_i,
  input  logic [AW-1:0] ldt_base_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_rvalid_i,
  input  logic [31:0]   mem_rdata_i,
  output logic          busy_o,
  output logic [RW-1:0] pend_reg_o,
  output logic          fill_o,
  output logic [AW-1:0] fill_base_o
);
  typedef enum logic [1:0] {F_IDLE, F_LO, F_HI} fstate_e;

  fstate_e       state_q;
  logic [AW-1:0] addr_q;
  logic [31:0]   lo_q;
  logic [RW-1:0] reg_q;
  logic [AW-1:0] table_base;

  assign table_base = sel_i.ti ? ldt_base_i : gdt_base_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= F_IDLE;
      addr_q  <= '0;
      lo_q    <= '0;
      reg_q   <= '0;
    end else begin
      unique case (state_q)
        F_IDLE: if (start_i) begin
          addr_q  <= table_base + AW'({sel_i.index, 3'b000});
          reg_q   <= start_reg_i;
          state_q <= F_LO;
        end
        F_LO: if (mem_rvalid_i) begin
          lo_q    <= mem_rdata_i;
          state_q <= F_HI;
        end
        F_HI: if (mem_rvalid_i) state_q <= F_IDLE;
        default: state_q <= F_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != F_IDLE);
  assign mem_req_o   = busy_o;
  assign mem_addr_o  = (state_q == F_HI) ? addr_q + AW'(4) : addr_q;
  assign pend_reg_o  = reg_q;
  assign fill_o      = (state_q == F_HI) && mem_rvalid_i;
  assign fill_base_o = desc_base(lo_q, mem_rdata_i);

  // R3
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));
endmodule

// File: rtl/seg_cache_bank.sv
module seg_cache_bank
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEG = 6,
  parameter int RW      = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_we_i,
  input  logic [RW-1:0] ld_reg_i,
  input  sel_t          ld_sel_i,
  input  logic          fill_i,
  input  logic [RW-1:0] fill_reg_i,
  input  logic [AW-1:0] fill_base_i,
  input  logic [RW-1:0] rd_reg_i,
  output logic [AW-1:0] rd_base_o,
  output logic          rd_valid_o,
  output logic [1:0]    cpl_o
);
  sel_t          sel_q   [NUM_SEG];
  logic [AW-1:0] base_q  [NUM_SEG];
  logic          valid_q [NUM_SEG];

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sel_q[i]   <= '0;
        base_q[i]  <= '0;
        valid_q[i] <= 1'b0;
      end else if (ld_we_i && ld_reg_i == RW'(i)) begin
        sel_q[i]   <= ld_sel_i;
        valid_q[i] <= 1'b0;
      end else if (fill_i && fill_reg_i == RW'(i)) begin
        base_q[i]  <= fill_base_i;
        valid_q[i] <= 1'b1;
      end
    end
  end

  always_comb begin
    rd_base_o  = '0;
    rd_valid_o = 1'b0;
    for (int i = 0; i < NUM_SEG; i++) begin
      if (rd_reg_i == RW'(i)) begin
        rd_base_o  = base_q[i];
        rd_valid_o = valid_q[i];
      end
    end
  end

  assign cpl_o = sel_q[0].rpl;
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_xlate_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fire_i,
  input  logic          valid_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] off_i,
  output logic          done_o,
  output logic [AW-1:0] lin_o,
  output logic          fault_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o  <= 1'b0;
      lin_o   <= '0;
      fault_o <= 1'b0;
    end else begin
      done_o <= fire_i;
      if (fire_i) begin
        fault_o <= !valid_i;
        lin_o   <= valid_i ? base_i + off_i : '0;
      end
    end
  end

  // R8
  fault_no_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o) |-> (lin_o == '0));
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEG = 6,
  parameter int RW      = $clog2(NUM_SEG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [31:0]   gdt_base_i,
  input  logic [31:0]   ldt_base_i,
  input  logic          ld_valid_i,
  input  logic [RW-1:0] ld_reg_i,
  input  logic [15:0]   ld_sel_i,
  output logic          ld_ready_o,
  output logic          mem_req_o,
  output logic [31:0]   mem_addr_o,
  input  logic          mem_rvalid_i,
  input  logic [31:0]   mem_rdata_i,
  output logic          busy_o,
  input  logic          xl_valid_i,
  input  logic [RW-1:0] xl_reg_i,
  input  logic [31:0]   xl_off_i,
  output logic          xl_ready_o,
  output logic          xl_done_o,
  output logic [31:0]   xl_lin_o,
  output logic          xl_fault_o,
  output logic [1:0]    cpl_o
);
  localparam logic [RW:0] SEG_LIM = (RW+1)'(NUM_SEG);

  sel_t          ld_sel;
  logic          ld_fire, ld_null, fetch_go;
  logic          xl_fire, xl_in_range;
  logic [RW-1:0] pend_reg;
  logic          fill;
  logic [AW-1:0] fill_base, rd_base;
  logic          rd_valid;

  assign ld_sel      = sel_t'(ld_sel_i);
  assign ld_null     = sel_is_null(ld_sel);
  assign ld_ready_o  = !busy_o;
  assign ld_fire     = ld_valid_i && ld_ready_o && ({1'b0, ld_reg_i} < SEG_LIM);
  assign fetch_go    = ld_fire && !ld_null;
  assign xl_ready_o  = !(busy_o && xl_reg_i == pend_reg);
  assign xl_fire     = xl_valid_i && xl_ready_o;
  assign xl_in_range = ({1'b0, xl_reg_i} < SEG_LIM);

  seg_desc_fetch #(.RW(RW)) u_fetch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (fetch_go),
    .start_reg_i  (ld_reg_i),
    .sel_i        (ld_sel),
    .gdt_base_i   (gdt_base_i),
    .ldt_base_i   (ldt_base_i),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .busy_o       (busy_o),
    .pend_reg_o   (pend_reg),
    .fill_o       (fill),
    .fill_base_o  (fill_base)
  );

  seg_cache_bank #(.NUM_SEG(NUM_SEG), .RW(RW)) u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ld_we_i     (ld_fire),
    .ld_reg_i    (ld_reg_i),
    .ld_sel_i    (ld_sel),
    .fill_i      (fill),
    .fill_reg_i  (pend_reg),
    .fill_base_i (fill_base),
    .rd_reg_i    (xl_reg_i),
    .rd_base_o   (rd_base),
    .rd_valid_o  (rd_valid),
    .cpl_o       (cpl_o)
  );

  seg_addr_gen u_agen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (xl_fire),
    .valid_i (rd_valid && xl_in_range),
    .base_i  (rd_base),
    .off_i   (xl_off_i),
    .done_o  (xl_done_o),
    .lin_o   (xl_lin_o),
    .fault_o (xl_fault_o)
  );

  // R7
  xl_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xl_valid_i && xl_ready_o) |=> xl_done_o);

  // R8
  null_no_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_valid_i && ld_ready_o && ld_sel_i[15:2] == '0) |=> !busy_o);

  // R9
  cpl_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_valid_i && ld_ready_o && ld_reg_i == '0) |=> (cpl_o == $past(ld_sel_i[1:0])));

  // R10
  bad_reg_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_valid_i && ld_ready_o && {1'b0, ld_reg_i} >= SEG_LIM) |=> !busy_o);
endmodule

// File: tb/sim_seg_xlate_unit.sv
`timescale 1ns/1ps
module sim_seg_xlate_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] gdt_base_i = 32'h0002_0000;
  logic [31:0] ldt_base_i = 32'h0040_0000;
  logic        ld_valid_i = 1'b0;
  logic [2:0]  ld_reg_i = '0;
  logic [15:0] ld_sel_i = '0;
  logic        ld_ready_o, mem_req_o, busy_o;
  logic [31:0] mem_addr_o;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        xl_valid_i = 1'b0;
  logic [2:0]  xl_reg_i = '0;
  logic [31:0] xl_off_i = '0;
  logic        xl_ready_o, xl_done_o, xl_fault_o;
  logic [31:0] xl_lin_o;
  logic [1:0]  cpl_o;

  int nchk = 0, nfail = 0;
  logic [31:0] m_base [6];
  bit          m_val  [6];
  logic [1:0]  m_cpl = 2'd0;
  logic [31:0] log0 = '0, log1 = '0;
  int          dly = 0;

  always #5 clk_i = ~clk_i;

  seg_xlate_unit u0 (.*);

  function automatic logic [31:0] mem_word(logic [31:0] a);
    return a * 32'h9E37_79B1 + 32'h0123_4567;
  endfunction

  function automatic logic [31:0] exp_base(logic [31:0] a);
    logic [31:0] lo = mem_word(a), hi = mem_word(a + 32'd4);
    return {hi[31:24], hi[7:0], lo[31:16]};
  endfunction

  function automatic logic [31:0] desc_addr(logic [15:0] s);
    return (s[2] ? ldt_base_i : gdt_base_i) + {16'h0, s[15:3], 3'b000};
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  // memory responder: random 0..2 cycle latency per read
  initial begin
    forever begin
      @(negedge clk_i);
      mem_rvalid_i = 1'b0;
      if (mem_req_o) begin
        if (dly == 0) begin
          mem_rvalid_i = 1'b1;
          mem_rdata_i  = mem_word(mem_addr_o);
          log0 = log1;
          log1 = mem_addr_o;
          dly  = $urandom_range(2, 0);
        end else dly--;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic wait_idle();
    while (busy_o) begin @(posedge clk_i); #1; end
  endtask

  task automatic do_load(int r, logic [15:0] s, bit do_wait);
    logic [31:0] a;
    bit nul;
    @(negedge clk_i);
    ld_valid_i = 1'b1; ld_reg_i = 3'(r); ld_sel_i = s;
    #1;
    while (!ld_ready_o) begin @(negedge clk_i); #1; end
    a = desc_addr(s);
    nul = (s[15:2] == 14'd0);
    @(posedge clk_i); #1;
    ld_valid_i = 1'b0;
    if (r < 6) begin
      if (r == 0) m_cpl = s[1:0];
      if (nul) begin
        m_val[r] = 0;
        chk(busy_o == 1'b0, "R8 null load starts no fetch", 32'(busy_o), 0);
      end else begin
        m_val[r]  = 1;
        m_base[r] = exp_base(a);
        chk(busy_o == 1'b1, "R5 busy after accepted load", 32'(busy_o), 1);
        if (do_wait) begin
          wait_idle();
          chk(log0 == a, "R2 descriptor low word address", log0, a);
          chk(log1 == a + 32'd4, "R3 high word address", log1, a + 32'd4);
        end
      end
      chk(cpl_o == m_cpl, "R9 cpl", 32'(cpl_o), 32'(m_cpl));
    end else begin
      chk(busy_o == 1'b0, "R10 load to absent register", 32'(busy_o), 0);
    end
  endtask

  task automatic do_xl(int r, logic [31:0] off, string tag);
    bit ok_entry;
    logic [31:0] e;
    @(negedge clk_i);
    xl_valid_i = 1'b1; xl_reg_i = 3'(r); xl_off_i = off;
    #1;
    while (!xl_ready_o) begin @(negedge clk_i); #1; end
    @(posedge clk_i); #1;
    xl_valid_i = 1'b0;
    ok_entry = (r < 6) && m_val[r];
    e = ok_entry ? m_base[r] + off : 32'h0;
    chk(xl_done_o == 1'b1, tag, 32'(xl_done_o), 1);
    chk(xl_fault_o == !ok_entry, tag, 32'(xl_fault_o), 32'(!ok_entry));
    chk(xl_lin_o == e, tag, xl_lin_o, e);
  endtask

  initial begin
    void'($urandom(32'd20250611));
    for (int i = 0; i < 6; i++) begin m_val[i] = 0; m_base[i] = '0; end
    #23 rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(busy_o == 0 && mem_req_o == 0, "R1 idle after reset", {busy_o, mem_req_o}, 0);
    chk(ld_ready_o == 1, "R1 ld_ready", 32'(ld_ready_o), 1);
    chk(cpl_o == 0, "R1 cpl", 32'(cpl_o), 0);
    for (int r = 0; r < 6; r++) do_xl(r, 32'h100, "R1 reset entry faults");

    // R2 worked example: base 0x20000, index 2 -> 0x20010
    do_load(2, {13'd2, 1'b0, 2'd3}, 1);
    chk(log0 == 32'h0002_0010, "R2 example address", log0, 32'h0002_0010);
    do_xl(2, 32'h0000_1000, "R7 R4 translate");
    do_xl(2, 32'hFFFF_FFF0, "R7 wrap");
    chk(mem_req_o == 0, "R7 no memory read", 32'(mem_req_o), 0);

    // R9 code register privilege
    do_load(0, {13'd5, 1'b0, 2'd3}, 1);
    chk(cpl_o == 2'd3, "R9 cpl=3", 32'(cpl_o), 3);
    do_load(0, {13'd6, 1'b1, 2'd0}, 1);
    do_xl(0, 32'h12, "R2 local table translate");

    // R8 null global selector, local index 0 is not null
    do_load(1, 16'h0003, 1);
    do_xl(1, 32'h55, "R8 null faults");
    do_load(3, 16'h0004, 1);
    do_xl(3, 32'h55, "R8 local index 0 valid");

    // R10 absent registers
    do_load(6, {13'd9, 1'b0, 2'd0}, 1);
    do_xl(6, 32'h10, "R10 translate reg 6 faults");
    do_xl(7, 32'h10, "R10 translate reg 7 faults");

    // R11 table base change keeps cached base, reload replaces it
    do_load(4, {13'd17, 1'b0, 2'd1}, 1);
    gdt_base_i = 32'h0100_0000;
    do_xl(4, 32'h20, "R11 cached base survives table move");
    do_load(4, {13'd17, 1'b0, 2'd1}, 1);
    do_xl(4, 32'h20, "R11 reload uses new table");

    // R5 R6 behaviour while a fetch is pending
    do_load(5, {13'd33, 1'b0, 2'd2}, 0);
    @(negedge clk_i);
    ld_valid_i = 1'b1; ld_reg_i = 3'd4; ld_sel_i = {13'd40, 1'b0, 2'd0};
    xl_valid_i = 1'b1; xl_reg_i = 3'd5;
    #1;
    chk(ld_ready_o == 0, "R5 load refused while busy", 32'(ld_ready_o), 0);
    chk(xl_ready_o == 0, "R6 stall on pending register", 32'(xl_ready_o), 0);
    xl_reg_i = 3'd4;
    #1;
    chk(xl_ready_o == 1, "R6 other register proceeds", 32'(xl_ready_o), 1);
    ld_valid_i = 1'b0; xl_valid_i = 1'b0;
    do_xl(5, 32'h3000, "R6 stalled translate completes with new base");
    wait_idle();
    do_xl(4, 32'h20, "R5 refused load had no effect");

    // random phase
    for (int it = 0; it < 500; it++) begin
      int r = $urandom_range(5, 0);
      if ($urandom_range(3, 0) == 0) begin
        logic [15:0] s = 16'($urandom);
        if ($urandom_range(7, 0) == 0) s = {14'd0, 2'($urandom)};
        if ($urandom_range(9, 0) == 0) gdt_base_i = $urandom;
        if ($urandom_range(9, 0) == 0) ldt_base_i = $urandom;
        do_load(r, s, 1);
      end else begin
        do_xl(r, $urandom, "R7 random translate");
      end
    end
    finish_run();
  end
endmodule